// File: doc/BRIEF.md
# Loop Stream Detector Controller

This block sits beside the micro-op queue and watches the micro-ops flowing into it. When a short loop passes by, the block records one iteration of its body in a local buffer and checks that body against a set of qualification limits. It then confirms that the next iteration repeats the recorded one exactly. A loop that passes both steps is replayed from the buffer, several micro-ops per cycle, while the upstream fetch and decode logic is told to sleep.

A loop is recognised when a taken branch jumps back to the address of the first recorded micro-op. Replay goes on until a branch misprediction or a pipeline flush ends it. Either event sends the controller back to idle and wakes the front end in the same cycle.

Top module: `lsd_ctrl`

## Requirements
- R1: A body is recorded from the first micro-op seen in IDLE. It closes on a taken micro-op whose target equals that first address, giving length L. L must not exceed DEPTH (28). A longer body sends the state to IDLE, and a body that is still open when its 29th micro-op arrives also sends the state to IDLE. While the body is open the state is CAPTURE.
- R2: A body with more than 8 taken micro-ops, the closing branch included, is rejected and the state returns to IDLE.
- R3: A body spanning more than 8 chunks is rejected. The chunk count starts at 1 and rises by one whenever a micro-op's 32-byte chunk id differs from the previous micro-op's.
- R4: A body with any micro-op whose micro-op-cache residency flag is low is rejected.
- R5: A body containing any micro-op flagged as a call or return is rejected.
- R6: A body whose push flags and pop flags differ in count is rejected.
- R7: A qualifying body moves the state to VERIFY. The next L micro-ops must match the recorded ones in address and taken flag, and must be cache resident and free of call/return. If they match, the state becomes REPLAY after the last one. The first mismatch returns the state to IDLE on that micro-op.
- R8: In REPLAY, rep_valid is high and lane k (k = 0..3) carries the payload of entry (p+k) mod L. The pointer p starts at 0 and advances by 4 modulo L each cycle.
- R9: fe_sleep is high exactly while the state is REPLAY and neither mispredict nor flush is asserted.
- R10: A mispredict or flush in any state drops fe_sleep and rep_valid in the same cycle and makes the state IDLE on the next cycle.
- R11: Micro-ops presented on the input during REPLAY have no effect on the replay stream.
- R12: The state output encodes IDLE=0, CAPTURE=1, VERIFY=2, REPLAY=3. After reset the state is IDLE with fe_sleep and rep_valid low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A micro-op is written into the queue this cycle |
| in_addr | input | AW | Address of the micro-op's instruction |
| in_target | input | AW | Branch target, meaningful when in_taken is high |
| in_uop | input | DW | Micro-op payload |
| in_taken | input | 1 | Micro-op is a taken branch |
| in_callret | input | 1 | Micro-op is a call or return |
| in_push | input | 1 | Micro-op pushes to the stack |
| in_pop | input | 1 | Micro-op pops from the stack |
| in_chunk | input | CW | 32-byte chunk id of the instruction |
| in_uc_hit | input | 1 | Micro-op is resident in the micro-op cache |
| mispredict | input | 1 | Branch misprediction |
| flush | input | 1 | Pipeline flush |
| rep_valid | output | 1 | Replay lanes are valid |
| rep_uop | output | LANES*DW | Replayed payloads, lane 0 in the low bits |
| fe_sleep | output | 1 | Front end may sleep |
| state | output | 2 | Controller state |

## Verification
The bench sweeps the loop length from 1 to 29. This separates lengths below the lane count, where one cycle wraps the buffer several times, from lengths that wrap only across cycles, and it finds the exact point where the buffer overflows. Each limit is driven once at its bound and once one step past it. Residency misses and call/return flags are placed at every position of a body, which shows that each micro-op is screened and not only the first or last. Mismatches are placed at every position of the confirming iteration, and aborts are applied in each state.

// File: rtl/lsd_ctrl.sv
module lsd_ctrl #(
  parameter int DEPTH      = 28,
  parameter int LANES      = 4,
  parameter int MAX_TAKEN  = 8,
  parameter int MAX_CHUNKS = 8,
  parameter int AW         = 16,
  parameter int DW         = 16,
  parameter int CW         = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [AW-1:0]       in_addr,
  input  logic [AW-1:0]       in_target,
  input  logic [DW-1:0]       in_uop,
  input  logic                in_taken,
  input  logic                in_callret,
  input  logic                in_push,
  input  logic                in_pop,
  input  logic [CW-1:0]       in_chunk,
  input  logic                in_uc_hit,
  input  logic                mispredict,
  input  logic                flush,
  output logic                rep_valid,
  output logic [LANES*DW-1:0] rep_uop,
  output logic                fe_sleep,
  output logic [1:0]          state
);
  localparam int IW   = $clog2(DEPTH + 1);
  localparam int CNTW = IW + 1;
  localparam int BW   = IW + 2;
  localparam int XW   = IW + $clog2(LANES + 1) + 1;

  typedef enum logic [1:0] {S_IDLE = 2'd0, S_CAPTURE = 2'd1, S_VERIFY = 2'd2, S_REPLAY = 2'd3} st_t;

  st_t             st_q;
  logic [IW-1:0]   cnt_q, len_q, vidx_q, rptr_q;
  logic [AW-1:0]   base_q;
  logic [CNTW-1:0] ntk_q, nch_q;
  logic [CW-1:0]   lastch_q;
  logic            allhit_q, anycr_q;
  logic [BW-1:0]   bal_q;

  logic [DW-1:0]   uop_mem   [DEPTH];
  logic [AW-1:0]   addr_mem  [DEPTH];
  logic            taken_mem [DEPTH];

  function automatic logic [IW-1:0] wrap(input logic [XW-1:0] x, input logic [IW-1:0] n);
    logic [XW-1:0] v;
    v = x;
    for (int i = 0; i <= LANES; i++)
      if (v >= XW'(n)) v = v - XW'(n);
    return v[IW-1:0];
  endfunction

  wire abort    = mispredict | flush;
  wire gather   = (st_q == S_IDLE) || (st_q == S_CAPTURE);
  wire start    = in_valid && (st_q == S_IDLE);
  wire [IW-1:0] cur_idx  = start ? '0 : cnt_q;
  wire [AW-1:0] base_eff = start ? in_addr : base_q;
  wire closing  = in_taken && (in_target == base_eff);

  wire [CNTW-1:0] ntk_n = (start ? '0 : ntk_q) + CNTW'(in_taken);
  wire [CNTW-1:0] nch_n = start ? CNTW'(1) : nch_q + CNTW'(in_chunk != lastch_q);
  wire            hit_n = (start ? 1'b1 : allhit_q) & in_uc_hit;
  wire            cr_n  = (start ? 1'b0 : anycr_q) | in_callret;
  wire [BW-1:0]   bal_n = (start ? '0 : bal_q) + BW'(in_push) - BW'(in_pop);

  wire qual = (32'(cur_idx) < DEPTH) && (32'(ntk_n) <= MAX_TAKEN) &&
              (32'(nch_n) <= MAX_CHUNKS) && hit_n && !cr_n && (bal_n == '0);

  wire vmatch = (in_addr == addr_mem[vidx_q]) && (in_taken == taken_mem[vidx_q]) &&
                in_uc_hit && !in_callret;
  wire vlast  = (vidx_q == len_q - IW'(1));
  wire vok    = vmatch && (!vlast || in_target == base_q);

  assign state     = st_q;
  assign rep_valid = (st_q == S_REPLAY) && !abort;
  assign fe_sleep  = (st_q == S_REPLAY) && !abort;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign rep_uop[k*DW +: DW] = uop_mem[wrap(XW'(rptr_q) + XW'(k), len_q)];
  end

  always_ff @(posedge clk) begin
    if (in_valid && gather && !abort && 32'(cur_idx) < DEPTH) begin
      uop_mem[cur_idx]   <= in_uop;
      addr_mem[cur_idx]  <= in_addr;
      taken_mem[cur_idx] <= in_taken;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= S_IDLE;
      cnt_q    <= '0;
      len_q    <= '0;
      vidx_q   <= '0;
      rptr_q   <= '0;
      base_q   <= '0;
      ntk_q    <= '0;
      nch_q    <= '0;
      lastch_q <= '0;
      allhit_q <= 1'b1;
      anycr_q  <= 1'b0;
      bal_q    <= '0;
    end else if (abort) begin
      st_q <= S_IDLE;
    end else begin
      unique case (st_q)
        S_IDLE, S_CAPTURE: if (in_valid) begin
          ntk_q    <= ntk_n;
          nch_q    <= nch_n;
          allhit_q <= hit_n;
          anycr_q  <= cr_n;
          bal_q    <= bal_n;
          lastch_q <= in_chunk;
          if (start) base_q <= in_addr;
          if (closing) begin
            if (qual) begin
              st_q   <= S_VERIFY;
              len_q  <= cur_idx + IW'(1);
              vidx_q <= '0;
            end else begin
              st_q <= S_IDLE;
            end
          end else if (32'(cur_idx) >= DEPTH) begin
            st_q <= S_IDLE;
          end else begin
            st_q  <= S_CAPTURE;
            cnt_q <= cur_idx + IW'(1);
          end
        end
        S_VERIFY: if (in_valid) begin
          if (!vok) begin
            st_q <= S_IDLE;
          end else if (vlast) begin
            st_q   <= S_REPLAY;
            rptr_q <= '0;
          end else begin
            vidx_q <= vidx_q + IW'(1);
          end
        end
        S_REPLAY: rptr_q <= wrap(XW'(rptr_q) + XW'(LANES), len_q);
        default:  st_q <= S_IDLE;
      endcase
    end
  end

  a_r10_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (mispredict || flush) |=> (st_q == S_IDLE));

  a_r7_replay_from_verify: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_REPLAY && $past(st_q) != S_REPLAY) |-> ($past(st_q) == S_VERIFY));

  a_r1_len_range: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_VERIFY || st_q == S_REPLAY) |-> (len_q != '0 && 32'(len_q) <= DEPTH));

  a_r8_ptr_range: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_REPLAY) |-> (rptr_q < len_q));

  a_r9_sleep_holds: assert property (@(posedge clk) disable iff (!rst_n)
    fe_sleep |=> (st_q == S_REPLAY));
endmodule

// File: tb/tb_lsd_ctrl.sv
module tb_lsd_ctrl;
  localparam int AW = 16, DW = 16, CW = 8, LANES = 4;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_taken = 0, in_callret = 0, in_push = 0, in_pop = 0, in_uc_hit = 1;
  logic [AW-1:0] in_addr = '0, in_target = '0;
  logic [DW-1:0] in_uop = '0;
  logic [CW-1:0] in_chunk = '0;
  logic mispredict = 0, flush = 0;
  logic rep_valid, fe_sleep;
  logic [LANES*DW-1:0] rep_uop;
  logic [1:0] state;

  int n_tests = 0, n_fail = 0;

  lsd_ctrl dut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_addr(in_addr),
    .in_target(in_target), .in_uop(in_uop), .in_taken(in_taken), .in_callret(in_callret),
    .in_push(in_push), .in_pop(in_pop), .in_chunk(in_chunk), .in_uc_hit(in_uc_hit),
    .mispredict(mispredict), .flush(flush), .rep_valid(rep_valid), .rep_uop(rep_uop),
    .fe_sleep(fe_sleep), .state(state));

  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic put(input int seed, input int i, input int L, input int ntk, input int nch,
                     input int miss, input int cr, input bit unbal, input bit bad);
    int base;
    base = 'h100 + seed * 64;
    in_valid   = 1;
    in_addr    = AW'(base + i + (bad ? 40 : 0));
    in_taken   = (i == L - 1) || (i < ntk - 1);
    in_target  = (i == L - 1) ? AW'(base) : AW'(base + i + 2);
    in_uop     = DW'(seed * 256 + i);
    in_chunk   = CW'((i * nch) / L);
    in_uc_hit  = (i != miss);
    in_callret = (i == cr);
    in_push    = (i == 0);
    in_pop     = (i == L - 1) && !unbal;
    step();
    in_valid = 0; in_taken = 0; in_callret = 0; in_push = 0; in_pop = 0; in_uc_hit = 1;
  endtask

  task automatic run_loop(input int seed, input int L, input int ntk, input int nch,
                          input int miss, input int cr, input bit unbal, input int mis2,
                          input string req);
    bit q;
    q = (L <= 28) && (ntk <= 8) && (nch <= 8) && (miss < 0) && (cr < 0) && !unbal;
    for (int i = 0; i < L; i++) begin
      put(seed, i, L, ntk, nch, miss, cr, unbal, 0);
      if (i == 0 && L > 1) chk(state == 2'd1, "R1 capture state", state, 1);
    end
    chk(state == (q ? 2'd2 : 2'd0), req, state, q ? 2 : 0);
    if (!q) return;
    for (int i = 0; i < L; i++) begin
      put(seed, i, L, ntk, nch, -1, -1, 0, i == mis2);
      if (i == mis2) begin
        chk(state == 2'd0, "R7 mismatch to idle", state, 0);
        return;
      end
    end
    chk(state == 2'd3, "R7 replay entered", state, 3);
    chk(fe_sleep && rep_valid, "R9 sleep in replay", fe_sleep, 1);
    for (int j = 0; j < 4; j++) begin
      for (int k = 0; k < LANES; k++) begin
        int e;
        e = seed * 256 + ((4 * j + k) % L);
        chk(rep_uop[k*DW +: DW] == DW'(e), (j % 2 == 1) ? "R11 replay ignores input" : "R8 replay lane",
            int'(rep_uop[k*DW +: DW]), e);
      end
      if (j % 2 == 0) begin
        in_valid = 1; in_addr = AW'(base_junk(seed)); in_uop = 16'hdead;
        in_taken = 1; in_target = AW'(base_junk(seed));
      end
      step();
      in_valid = 0; in_taken = 0;
    end
    if (seed % 2 == 0) mispredict = 1; else flush = 1;
    #1;
    chk(!fe_sleep && !rep_valid, "R10 sleep drops same cycle", fe_sleep, 0);
    chk(state == 2'd3, "R9 still replay before edge", state, 3);
    step();
    mispredict = 0; flush = 0;
    chk(state == 2'd0, "R10 idle after abort", state, 0);
    chk(!fe_sleep, "R9 awake in idle", fe_sleep, 0);
  endtask

  function automatic int base_junk(input int seed);
    return 'h100 + seed * 64 + 7;
  endfunction

  initial begin
    #(4 * 150000);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int seed;
    seed = 1;
    repeat (3) @(negedge clk);
    chk(state == 2'd0, "R12 reset state", state, 0);
    chk(!fe_sleep && !rep_valid, "R12 reset outputs", fe_sleep, 0);
    rst_n = 1;
    step();
    // R1/R8: length sweep, including overflow at 29
    for (int L = 1; L <= 29; L++) begin
      run_loop(seed, L, 1, 1, -1, -1, 0, -1, "R1 length qualify");
      seed++;
    end
    // R2 taken limit
    run_loop(seed++, 12, 8, 1, -1, -1, 0, -1, "R2 taken at limit");
    run_loop(seed++, 12, 9, 1, -1, -1, 0, -1, "R2 taken over limit");
    // R3 chunk limit
    run_loop(seed++, 20, 1, 8, -1, -1, 0, -1, "R3 chunks at limit");
    run_loop(seed++, 20, 1, 9, -1, -1, 0, -1, "R3 chunks over limit");
    run_loop(seed++, 28, 8, 8, -1, -1, 0, -1, "R3 all limits together");
    // R4 residency at every position
    for (int m = 0; m < 6; m++) run_loop(seed++, 6, 1, 1, m, -1, 0, -1, "R4 cache miss rejects");
    // R5 call/return at every position
    for (int m = 0; m < 6; m++) run_loop(seed++, 6, 1, 1, -1, m, 0, -1, "R5 call/ret rejects");
    // R6 stack balance
    run_loop(seed++, 5, 1, 1, -1, -1, 1, -1, "R6 unbalanced rejects");
    run_loop(seed++, 1, 1, 1, -1, -1, 1, -1, "R6 lone push rejects");
    // R7 mismatch at every position
    for (int m = 0; m < 5; m++) run_loop(seed++, 5, 2, 2, -1, -1, 0, m, "R7 verify qualify");
    // R10 abort in CAPTURE
    put(seed, 0, 6, 1, 1, -1, -1, 0, 0);
    put(seed, 1, 6, 1, 1, -1, -1, 0, 0);
    flush = 1; step(); flush = 0;
    chk(state == 2'd0, "R10 flush in capture", state, 0);
    seed++;
    // R10 abort in VERIFY
    for (int i = 0; i < 4; i++) put(seed, i, 4, 1, 1, -1, -1, 0, 0);
    chk(state == 2'd2, "R7 verify reached", state, 2);
    put(seed, 0, 4, 1, 1, -1, -1, 0, 0);
    mispredict = 1; #1;
    chk(!fe_sleep, "R9 no sleep in verify", fe_sleep, 0);
    step(); mispredict = 0;
    chk(state == 2'd0, "R10 mispredict in verify", state, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule